// File: doc/BRIEF.md
# Consecutive out-of-limit alert filter

This block screens a stream of 8-bit temperature results against a high and a low threshold. It raises an alert only after a programmed run of back-to-back violations, so a single noisy conversion is not reported. The run length comes from a thermometer-coded field inside a shared control byte. The other bits of that byte belong to other functions and are ignored here.

Each result arrives with a one-cycle valid strobe. Two sticky flags record which threshold has been crossed since the last clear. The alert stays latched until software reads the status and pulses the clear input. To cover a local and a remote sensor, place one instance per channel.

Top module: `temp_alert_filter`

## Requirements
- R1: A valid result is a violation when it is strictly greater than the high threshold or strictly less than the low threshold. A result equal to either threshold is in range.
- R2: The required run length is read from control bits 3:1 as a thermometer code: 000 gives 1, 001 gives 2, 011 gives 3 and 111 gives 4.
- R3: For any other pattern in bits 3:1, the run length is 1 plus the number of consecutive ones counted upward from bit 1. So 110 gives 1 and 101 gives 2.
- R4: Control bit 7, bits 6:4 and bit 0 have no effect on filtering.
- R5: The run count rises by one on each valid violation and drops to zero on each valid in-range result. It holds while no valid strobe is present.
- R6: The alert output rises at the clock edge where the run count reaches the required length. Once high, it stays high through later in-range results until a clear.
- R7: The run count saturates at the required length and never wraps. After a clear, a fault that is still present re-raises the alert on its next violation.
- R8: The high flag is set by a valid result above the high threshold, and the low flag by a valid result below the low threshold. Both flags hold until a clear.
- R9: A clear pulse drops the alert and both flags at the next edge and leaves the run count unchanged. Any result strobed in the same cycle is discarded.
- R10: The asynchronous active-low reset zeroes the alert, the flags and the run count. With the default settings (control 01h, high threshold 55h, low threshold 00h), one result above 55h raises the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_valid_i | input | 1 | One-cycle strobe marking a new result |
| meas_i | input | 8 | Measured temperature code |
| hi_lim_i | input | 8 | High threshold |
| lo_lim_i | input | 8 | Low threshold |
| run_cfg_i | input | 8 | Control byte; bits 3:1 select the run length |
| clr_i | input | 1 | Status-read clear pulse |
| alert_o | output | 1 | Latched filtered alert |
| hi_flag_o | output | 1 | Sticky flag: high threshold exceeded |
| lo_flag_o | output | 1 | Sticky flag: below the low threshold |

## Verification
Results equal to each threshold are run against results one code beyond it, which separates a strict comparison from an inclusive one. Violation runs are broken by in-range results and by idle cycles, which separates a run reset from a mere pause. All four legal run codes are driven, along with malformed codes and codes with the foreign bits set, so a decoder that reads the wrong bits or the wrong direction gives a different alert cycle. A long run followed by a clear and one more violation exposes a counter that wraps or is cleared by the status read.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned FIELD_LSB = 1;
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned MAX_RUN   = FIELD_W + 1;
  localparam int unsigned RUN_W     = $clog2(MAX_RUN + 1);

  // power-on values of the surrounding register file
  localparam logic [DATA_W-1:0] HI_LIM_DFLT = 8'h55;
  localparam logic [DATA_W-1:0] LO_LIM_DFLT = 8'h00;
  localparam logic [CFG_W-1:0]  RUN_CFG_DFLT = 8'h01;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] meas_i,
  input  logic [DATA_W-1:0] hi_lim_i,
  input  logic [DATA_W-1:0] lo_lim_i,
  output logic              above_o,
  output logic              below_o
);
  always_comb begin
    above_o = meas_i > hi_lim_i;
    below_o = meas_i < lo_lim_i;
  end
endmodule

// File: rtl/run_len_decode.sv
module run_len_decode #(
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned FIELD_LSB = 1,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned RUN_W     = 3
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [RUN_W-1:0] need_o
);
  localparam int unsigned MAX_RUN = FIELD_W + 1;

  logic [FIELD_W-1:0] field;
  logic [FIELD_W-1:0] ones;  // ones[i]: bits 0..i of field all set

  assign field = cfg_i[FIELD_LSB +: FIELD_W];

  generate
    for (genvar i = 0; i < FIELD_W; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign ones[i] = field[i];
      end else begin : g_next
        assign ones[i] = ones[i-1] & field[i];
      end
    end
  endgenerate

  always_comb begin
    need_o = RUN_W'(1 + $countones(ones));
    // R2
    need_range_chk: assert (need_o >= RUN_W'(1) && need_o <= RUN_W'(MAX_RUN));
  end
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int unsigned RUN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             viol_i,
  input  logic             clr_i,
  input  logic [RUN_W-1:0] need_i,
  output logic             alert_o
);
  logic [RUN_W-1:0] run_q, run_d;
  logic             alert_d;

  always_comb begin
    run_d   = run_q;
    alert_d = alert_o;
    if (clr_i) begin
      alert_d = 1'b0;  // sample in this cycle is dropped
    end else if (valid_i) begin
      if (viol_i) begin
        run_d   = (run_q >= need_i) ? need_i : run_q + RUN_W'(1);
        alert_d = alert_o | (run_d >= need_i);
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      alert_o <= 1'b0;
    end else begin
      run_q   <= run_d;
      alert_o <= alert_d;
    end
  end

  // R6
  alert_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o && !clr_i |=> alert_o);
  // R9
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !alert_o && $stable(run_q));
  // R5
  run_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !viol_i && !clr_i |=> run_q == '0);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !clr_i |=> $stable(run_q));
  // R7
  run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && viol_i && !clr_i |=> run_q != '0 && run_q <= $past(need_i));
endmodule

// File: rtl/temp_alert_filter.sv
module temp_alert_filter
  import temp_alert_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CFG_W,
  parameter int unsigned FL = FIELD_LSB,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          meas_valid_i,
  input  logic [DW-1:0] meas_i,
  input  logic [DW-1:0] hi_lim_i,
  input  logic [DW-1:0] lo_lim_i,
  input  logic [CW-1:0] run_cfg_i,
  input  logic          clr_i,
  output logic          alert_o,
  output logic          hi_flag_o,
  output logic          lo_flag_o
);
  localparam int unsigned RW = $clog2(FW + 2);

  logic          above, below;
  logic [RW-1:0] need;
  logic          take;

  limit_cmp #(.DATA_W(DW)) u_cmp (
    .meas_i  (meas_i),
    .hi_lim_i(hi_lim_i),
    .lo_lim_i(lo_lim_i),
    .above_o (above),
    .below_o (below)
  );

  run_len_decode #(.CFG_W(CW), .FIELD_LSB(FL), .FIELD_W(FW), .RUN_W(RW)) u_dec (
    .cfg_i (run_cfg_i),
    .need_o(need)
  );

  run_counter #(.RUN_W(RW)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(meas_valid_i),
    .viol_i (above | below),
    .clr_i  (clr_i),
    .need_i (need),
    .alert_o(alert_o)
  );

  assign take = meas_valid_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_flag_o <= 1'b0;
      lo_flag_o <= 1'b0;
    end else if (clr_i) begin
      hi_flag_o <= 1'b0;
      lo_flag_o <= 1'b0;
    end else begin
      hi_flag_o <= hi_flag_o | (take & above);
      lo_flag_o <= lo_flag_o | (take & below);
    end
  end

  // R8
  hi_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_flag_o && !clr_i |=> hi_flag_o);
  // R8
  lo_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_flag_o && !clr_i |=> lo_flag_o);
  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hi_flag_o && !lo_flag_o);
  // R6
  alert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> $past(meas_valid_i) && !$past(clr_i));
endmodule

// File: tb/sim_temp_alert_filter.sv
`timescale 1ns/1ps
module sim_temp_alert_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       meas_valid_i = 1'b0;
  logic [7:0] meas_i = 8'h00;
  logic [7:0] hi_lim_i = 8'h55;
  logic [7:0] lo_lim_i = 8'h00;
  logic [7:0] run_cfg_i = 8'h01;
  logic       clr_i = 1'b0;
  logic       alert_o, hi_flag_o, lo_flag_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  temp_alert_filter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .meas_valid_i(meas_valid_i), .meas_i(meas_i),
    .hi_lim_i(hi_lim_i), .lo_lim_i(lo_lim_i), .run_cfg_i(run_cfg_i), .clr_i(clr_i),
    .alert_o(alert_o), .hi_flag_o(hi_flag_o), .lo_flag_o(lo_flag_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       clr;
    logic       vld;
    logic [7:0] m;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] cfg;
    logic       ea;
    logic       eh;
    logic       el;
  } vec_t;

  function automatic vec_t mk(input logic [3:0] req, input logic clr, input logic vld,
                              input logic [7:0] m, input logic [7:0] cfg,
                              input logic ea, input logic eh, input logic el);
    vec_t v;
    v.req = req; v.clr = clr; v.vld = vld; v.m = m;
    v.hi = 8'h55; v.lo = 8'h10; v.cfg = cfg;
    v.ea = ea; v.eh = eh; v.el = el;
    return v;
  endfunction

  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    mk(1, 0, 1, 8'h55, 8'h01, 0, 0, 0), // R1 equal high
    mk(1, 0, 1, 8'h10, 8'h01, 0, 0, 0), // R1 equal low
    mk(1, 0, 1, 8'h56, 8'h01, 1, 1, 0), // R1 one above
    mk(9, 1, 0, 8'h00, 8'h01, 0, 0, 0), // R9 clear
    mk(1, 0, 1, 8'h0F, 8'h01, 1, 0, 1), // R1 one below
    mk(6, 0, 1, 8'h20, 8'h01, 1, 0, 1), // R6 held
    mk(9, 1, 0, 8'h00, 8'h01, 0, 0, 0),
    mk(2, 0, 1, 8'h60, 8'h07, 0, 1, 0), // R2 need 3: run 1
    mk(5, 0, 0, 8'h60, 8'h07, 0, 1, 0), // R5 idle
    mk(5, 0, 1, 8'h60, 8'h07, 0, 1, 0), // run 2
    mk(5, 0, 1, 8'h20, 8'h07, 0, 1, 0), // R5 run reset
    mk(5, 0, 1, 8'h60, 8'h07, 0, 1, 0), // run 1
    mk(8, 0, 1, 8'h05, 8'h07, 0, 1, 1), // R8 low flag, run 2
    mk(2, 0, 1, 8'h60, 8'h07, 1, 1, 1), // R2 run 3 alerts
    mk(6, 0, 1, 8'h20, 8'h07, 1, 1, 1), // R6 held
    mk(9, 1, 0, 8'h00, 8'h07, 0, 0, 0),
    mk(4, 0, 1, 8'h60, 8'h8F, 0, 1, 0), // R4 bit7/bit0 set, need 4
    mk(4, 0, 1, 8'h60, 8'h8F, 0, 1, 0),
    mk(4, 0, 1, 8'h60, 8'h8F, 0, 1, 0),
    mk(2, 0, 1, 8'h60, 8'h8F, 1, 1, 0), // R2 run 4
    mk(7, 0, 1, 8'h60, 8'h8F, 1, 1, 0), // R7 saturating
    mk(7, 0, 1, 8'h60, 8'h8F, 1, 1, 0),
    mk(7, 0, 1, 8'h60, 8'h8F, 1, 1, 0),
    mk(7, 0, 1, 8'h60, 8'h8F, 1, 1, 0),
    mk(9, 1, 1, 8'h20, 8'h8F, 0, 0, 0), // R9 sample discarded
    mk(7, 0, 1, 8'h60, 8'h8F, 1, 1, 0), // R7 re-alert, no wrap
    mk(9, 1, 0, 8'h00, 8'h8F, 0, 0, 0),
    mk(3, 0, 1, 8'h20, 8'h0C, 0, 0, 0), // R3 field 110
    mk(3, 0, 1, 8'h60, 8'h0C, 1, 1, 0), // R3 need 1
    mk(9, 1, 0, 8'h00, 8'h0C, 0, 0, 0),
    mk(3, 0, 1, 8'h20, 8'h0A, 0, 0, 0), // R3 field 101
    mk(3, 0, 1, 8'h60, 8'h0A, 0, 1, 0),
    mk(3, 0, 1, 8'h60, 8'h0A, 1, 1, 0), // R3 need 2
    mk(9, 1, 0, 8'h00, 8'h0A, 0, 0, 0),
    mk(4, 0, 1, 8'h20, 8'h72, 0, 0, 0), // R4 bits 6:4 set, field 001
    mk(4, 0, 1, 8'h60, 8'h72, 0, 1, 0),
    mk(4, 0, 1, 8'h60, 8'h72, 1, 1, 0), // R4 need 2
    mk(9, 1, 0, 8'h00, 8'h72, 0, 0, 0)
  };

  task automatic check(input int req, input string what,
                       input logic ea, input logic eh, input logic el);
    n_run++;
    if ({alert_o, hi_flag_o, lo_flag_o} !== {ea, eh, el}) begin
      n_fail++;
      $display("FAIL R%0d %s: alert/hi/lo got %b%b%b expected %b%b%b",
               req, what, alert_o, hi_flag_o, lo_flag_o, ea, eh, el);
    end
  endtask

  task automatic step(input logic clr, input logic vld, input logic [7:0] m);
    clr_i = clr; meas_valid_i = vld; meas_i = m;
    @(negedge clk_i);
    clr_i = 1'b0; meas_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(10, "reset state", 0, 0, 0);                   // R10
    step(0, 1, 8'h00);
    check(10, "default, meas equal low", 0, 0, 0);       // R10
    step(0, 1, 8'h56);
    check(10, "default, single excursion", 1, 1, 0);     // R10
    step(1, 0, 8'h00);
    check(9, "clear after default", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      hi_lim_i = TBL[i].hi; lo_lim_i = TBL[i].lo; run_cfg_i = TBL[i].cfg;
      step(TBL[i].clr, TBL[i].vld, TBL[i].m);
      check(int'(TBL[i].req), $sformatf("row %0d", i), TBL[i].ea, TBL[i].eh, TBL[i].el);
    end

    run_cfg_i = 8'h01;
    step(0, 1, 8'h60);
    check(6, "alert before reset", 1, 1, 0);
    #1 rst_ni = 1'b0;
    #1 check(10, "async reset", 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 1, 8'h20);
    check(10, "after reset in range", 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule